// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block gathers single-cycle event pulses from the internal engines of a network controller into one byte of pending status. The engines are the command engine, the receive engine, the management-bus engine and the pause logic. From that status and a mask byte it drives one level-sensitive interrupt line. Software acknowledges a pending event by writing a one to its status bit. Software uses the mask byte to silence single sources, to silence everything at once, or to raise an interrupt of its own.

The command engine reports two separate pulses: one when it becomes idle and one when it suspends. A mode input selects how these reach the not-active status bit. In idle-only mode, only the idle pulse is reported. In the other mode, either pulse is reported. The register write strobes come from a bus decoder outside this block. Both bytes are presented continuously as outputs so that the decoder can return them on reads.

Top module: `isr_unit`

## Requirements
- R1: After reset the status byte is 0x00, the mask byte is 0x01 (global mask set, all per-source masks clear) and `irq_o` is low.
- R2: An event pulse sets its status bit on the next clock edge. The bit positions are: command done → bit 7, frame received → bit 6, not-active → bit 5, receive stalled → bit 4, management done → bit 3, pause → bit 0. A set bit stays set until it is acknowledged.
- R3: A status write clears every status bit whose write-data bit is 1. Write-data bits that are 0 leave their status bits unchanged, and a status write never sets a bit.
- R4: When an event and an acknowledge of the same bit occur in the same cycle, the bit is set after that edge.
- R5: With `idle_only_i` = 1, only `cu_idle_i` sets bit 5. With `idle_only_i` = 0, either `cu_idle_i` or `cu_susp_i` sets bit 5.
- R6: A mask write stores write-data bits 7..2 and 0 into the mask byte on the next edge. Mask bit 1 always reads 0.
- R7: A mask write with write-data bit 1 = 1 sets status bit 2 (the software interrupt) on the same edge.
- R8: `irq_o` is high exactly when some status bit is set and its enabling mask bit is 0, and mask bit 0 is 0. The enabling mask bits are: status 7 ← mask 7, 6 ← 6, 5 ← 5, 4 ← 4, 3 ← 3, 0 ← 2. Status bit 2 is gated by mask bit 0 only.
- R9: While mask bit 0 is 1, `irq_o` is low whatever the status and the other mask bits hold.
- R10: Status bit 1 is reserved and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_done_i | input | 1 | Command completed pulse |
| frame_rx_i | input | 1 | Frame received pulse |
| cu_idle_i | input | 1 | Command engine became idle |
| cu_susp_i | input | 1 | Command engine suspended |
| ru_stall_i | input | 1 | Receive engine out of resources/stopped |
| mgmt_done_i | input | 1 | Management-bus cycle finished |
| pause_i | input | 1 | Pause frame event |
| idle_only_i | input | 1 | Mode: report only the idle event on bit 5 |
| stat_wr_i | input | 1 | Status (acknowledge) write strobe |
| stat_wdata_i | input | 8 | Status write data, ones clear |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 8 | Mask write data |
| stat_o | output | 8 | Pending status byte |
| mask_o | output | 8 | Mask byte |
| irq_o | output | 1 | Level interrupt request |

## Verification
Every status and mask result is due one clock edge after the cycle in which the event pulse or write strobe is presented. The interrupt line is a combinational function of the two registered bytes, so it follows in that same cycle. The bench drives its inputs just after a falling edge and lets one rising edge pass. It advances its own model at that edge and compares all three outputs at the next falling edge. A failure is therefore pinned to the single stimulus cycle that caused it.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int unsigned STAT_W = 8;

  // status bit positions (software-visible)
  localparam int unsigned ST_CMD   = 7;
  localparam int unsigned ST_FRAME = 6;
  localparam int unsigned ST_NACT  = 5;
  localparam int unsigned ST_RSTL  = 4;
  localparam int unsigned ST_MGMT  = 3;
  localparam int unsigned ST_SWI   = 2;
  localparam int unsigned ST_RSV   = 1;
  localparam int unsigned ST_PAUSE = 0;

  // mask bit positions
  localparam int unsigned MK_PAUSE = 2;
  localparam int unsigned MK_SWREQ = 1;
  localparam int unsigned MK_ALL   = 0;

  localparam logic [STAT_W-1:0] MASK_RST = 8'h01;

  typedef struct packed {
    logic cmd_done;
    logic frame_rx;
    logic cu_idle;
    logic cu_susp;
    logic ru_stall;
    logic mgmt_done;
    logic pause;
  } evt_t;

  // per-status-bit enable from the mask byte (global mask excluded)
  function automatic logic [STAT_W-1:0] mask_to_en(input logic [STAT_W-1:0] m);
    logic [STAT_W-1:0] en;
    en           = '0;
    en[ST_CMD]   = ~m[ST_CMD];
    en[ST_FRAME] = ~m[ST_FRAME];
    en[ST_NACT]  = ~m[ST_NACT];
    en[ST_RSTL]  = ~m[ST_RSTL];
    en[ST_MGMT]  = ~m[ST_MGMT];
    en[ST_SWI]   = 1'b1;
    en[ST_RSV]   = ~m[MK_SWREQ];
    en[ST_PAUSE] = ~m[MK_PAUSE];
    return en;
  endfunction
endpackage

// File: rtl/isr_event_merge.sv
module isr_event_merge
  import isr_pkg::*;
(
  input  evt_t              evt_i,
  input  logic              idle_only_i,
  input  logic              swi_req_i,
  output logic [STAT_W-1:0] set_o
);
  always_comb begin
    set_o           = '0;
    set_o[ST_CMD]   = evt_i.cmd_done;
    set_o[ST_FRAME] = evt_i.frame_rx;
    set_o[ST_NACT]  = evt_i.cu_idle | (~idle_only_i & evt_i.cu_susp);
    set_o[ST_RSTL]  = evt_i.ru_stall;
    set_o[ST_MGMT]  = evt_i.mgmt_done;
    set_o[ST_SWI]   = swi_req_i;
    set_o[ST_PAUSE] = evt_i.pause;
  end
endmodule

// File: rtl/isr_status_reg.sv
module isr_status_reg
  import isr_pkg::*;
#(
  parameter int unsigned W   = STAT_W,
  parameter int unsigned RSV = ST_RSV
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic [W-1:0] clr_data_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] clr;
  assign clr = clr_wr_i ? clr_data_i : '0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == RSV) begin : g_rsv
      assign stat_o[i] = 1'b0;
    end else begin : g_flop
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q <= 1'b0;
        else if (set_i[i]) q <= 1'b1;  // new event beats acknowledge
        else if (clr[i])   q <= 1'b0;
      end
      assign stat_o[i] = q;
    end
  end
endmodule

// File: rtl/isr_mask_reg.sv
module isr_mask_reg
  import isr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] mask_o,
  output logic              swi_req_o
);
  logic [STAT_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= MASK_RST;
    else if (wr_i) mask_q <= wdata_i & ~(STAT_W'(1) << MK_SWREQ);
  end

  assign mask_o    = mask_q;
  assign swi_req_o = wr_i & wdata_i[MK_SWREQ];
endmodule

// File: rtl/isr_irq_gate.sv
module isr_irq_gate
  import isr_pkg::*;
(
  input  logic [STAT_W-1:0] stat_i,
  input  logic [STAT_W-1:0] mask_i,
  output logic              irq_o
);
  logic [STAT_W-1:0] en;
  assign en    = mask_to_en(mask_i);
  assign irq_o = ~mask_i[MK_ALL] & |(stat_i & en);
endmodule

// File: rtl/isr_unit.sv
module isr_unit
  import isr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_done_i,
  input  logic       frame_rx_i,
  input  logic       cu_idle_i,
  input  logic       cu_susp_i,
  input  logic       ru_stall_i,
  input  logic       mgmt_done_i,
  input  logic       pause_i,
  input  logic       idle_only_i,
  input  logic       stat_wr_i,
  input  logic [7:0] stat_wdata_i,
  input  logic       mask_wr_i,
  input  logic [7:0] mask_wdata_i,
  output logic [7:0] stat_o,
  output logic [7:0] mask_o,
  output logic       irq_o
);
  evt_t              evt;
  logic              swi_req;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] stat;
  logic [STAT_W-1:0] mask;

  assign evt = '{cmd_done: cmd_done_i, frame_rx: frame_rx_i, cu_idle: cu_idle_i,
                 cu_susp: cu_susp_i, ru_stall: ru_stall_i, mgmt_done: mgmt_done_i,
                 pause: pause_i};

  isr_mask_reg u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (mask_wr_i),
    .wdata_i  (mask_wdata_i),
    .mask_o   (mask),
    .swi_req_o(swi_req)
  );

  isr_event_merge u_merge (
    .evt_i      (evt),
    .idle_only_i(idle_only_i),
    .swi_req_i  (swi_req),
    .set_o      (set_vec)
  );

  isr_status_reg #(.W(STAT_W), .RSV(ST_RSV)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_vec),
    .clr_wr_i  (stat_wr_i),
    .clr_data_i(stat_wdata_i),
    .stat_o    (stat)
  );

  isr_irq_gate u_gate (
    .stat_i(stat),
    .mask_i(mask),
    .irq_o (irq_o)
  );

  assign stat_o = stat;
  assign mask_o = mask;
endmodule

// File: rtl/isr_unit_checker.sv
module isr_unit_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frame_rx_i,
  input logic       cu_idle_i,
  input logic       cu_susp_i,
  input logic       idle_only_i,
  input logic       stat_wr_i,
  input logic [7:0] stat_wdata_i,
  input logic       mask_wr_i,
  input logic [7:0] mask_wdata_i,
  input logic [7:0] stat_o,
  input logic [7:0] mask_o,
  input logic       irq_o
);
  p_event_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_rx_i |=> stat_o[6]);

  p_hold_without_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_wr_i |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

  p_ack_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr_i && stat_wdata_i[6] && !frame_rx_i) |=> !stat_o[6]);

  p_set_beats_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_rx_i && stat_wr_i && stat_wdata_i[6]) |=> stat_o[6]);

  p_susp_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_only_i && cu_susp_i && !cu_idle_i && !stat_o[5]) |=> !stat_o[5]);

  p_mask_store_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_wr_i |=> (mask_o == (($past(mask_wdata_i)) & 8'hFD)));

  p_swi_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_wr_i && mask_wdata_i[1]) |=> stat_o[2]);

  p_global_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_o[0] |-> !irq_o);

  p_reserved_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_o[1] && !mask_o[1]);
endmodule

bind isr_unit isr_unit_checker u_isr_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_rx_i  (frame_rx_i),
  .cu_idle_i   (cu_idle_i),
  .cu_susp_i   (cu_susp_i),
  .idle_only_i (idle_only_i),
  .stat_wr_i   (stat_wr_i),
  .stat_wdata_i(stat_wdata_i),
  .mask_wr_i   (mask_wr_i),
  .mask_wdata_i(mask_wdata_i),
  .stat_o      (stat_o),
  .mask_o      (mask_o),
  .irq_o       (irq_o)
);

// File: tb/isr_unit_bench.sv
module isr_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 3000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] ev = '0;  // {cmd,frame,idle,susp,rstall,mgmt,pause}
  logic       idle_only = 1'b0;
  logic       stat_wr = 1'b0;
  logic [7:0] stat_wd = '0;
  logic       mask_wr = 1'b0;
  logic [7:0] mask_wd = '0;
  logic [7:0] stat_o, mask_o;
  logic       irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] m_stat = 8'h00;
  logic [7:0] m_mask = 8'h01;

  always #(CLK_PERIOD/2) clk = ~clk;

  isr_unit u_isr_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_done_i(ev[6]), .frame_rx_i(ev[5]), .cu_idle_i(ev[4]), .cu_susp_i(ev[3]),
    .ru_stall_i(ev[2]), .mgmt_done_i(ev[1]), .pause_i(ev[0]),
    .idle_only_i(idle_only),
    .stat_wr_i(stat_wr), .stat_wdata_i(stat_wd),
    .mask_wr_i(mask_wr), .mask_wdata_i(mask_wd),
    .stat_o(stat_o), .mask_o(mask_o), .irq_o(irq_o)
  );

  function automatic logic [7:0] f_set(input logic [6:0] e, input logic io,
                                       input logic mw, input logic [7:0] md);
    logic [7:0] s;
    s    = '0;
    s[7] = e[6];
    s[6] = e[5];
    s[5] = e[4] | (~io & e[3]);
    s[4] = e[2];
    s[3] = e[1];
    s[2] = mw & md[1];
    s[0] = e[0];
    return s;
  endfunction

  function automatic logic f_irq(input logic [7:0] s, input logic [7:0] m);
    logic [7:0] en;
    en = {~m[7], ~m[6], ~m[5], ~m[4], ~m[3], 1'b1, 1'b0, ~m[2]};
    return ~m[0] & |(s & en);
  endfunction

  task automatic check8(input string req, input string what, input logic [7:0] act,
                        input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  // inputs already driven; one edge, update model, compare at falling edge
  task automatic step(input string rs, input string rm, input string ri);
    @(posedge clk);
    m_stat = ((m_stat & ~(stat_wr ? stat_wd : 8'h00)) | f_set(ev, idle_only, mask_wr, mask_wd))
             & 8'hFD;
    if (mask_wr) m_mask = mask_wd & 8'hFD;
    @(negedge clk);
    check8(rs, "stat", stat_o, m_stat);
    check8(rm, "mask", mask_o, m_mask);
    check8(ri, "irq", {7'd0, irq_o}, {7'd0, f_irq(m_stat, m_mask)});
    ev = '0; stat_wr = 1'b0; stat_wd = '0; mask_wr = 1'b0; mask_wd = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int unsigned r;
    r = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check8("R1", "stat", stat_o, 8'h00);
    check8("R1", "mask", mask_o, 8'h01);
    check8("R1", "irq", {7'd0, irq_o}, 8'h00);

    // R9 global mask holds irq low while an event is pending
    ev = 7'b0100000; step("R2", "R6", "R9");
    // unmask all sources
    mask_wr = 1'b1; mask_wd = 8'h00; step("R2", "R6", "R8");
    // R3 zero write leaves bit, one write clears it
    stat_wr = 1'b1; stat_wd = 8'h00; step("R3", "R6", "R8");
    stat_wr = 1'b1; stat_wd = 8'h40; step("R3", "R6", "R8");
    // R2 each source lands on its own bit
    for (int i = 0; i < 7; i++) begin
      ev = 7'(1 << i); step("R2", "R6", "R8");
      stat_wr = 1'b1; stat_wd = 8'hFF; step("R3", "R6", "R8");
    end
    // R4 event and acknowledge in the same cycle
    ev = 7'b0100000; step("R2", "R6", "R8");
    ev = 7'b0100000; stat_wr = 1'b1; stat_wd = 8'h40; step("R4", "R6", "R8");
    stat_wr = 1'b1; stat_wd = 8'hFF; step("R3", "R6", "R8");
    // R5 idle-only mode: suspend ignored, idle reported
    idle_only = 1'b1;
    ev = 7'b0001000; step("R5", "R6", "R8");
    ev = 7'b0010000; step("R5", "R6", "R8");
    stat_wr = 1'b1; stat_wd = 8'hFF; step("R3", "R6", "R8");
    idle_only = 1'b0;
    ev = 7'b0001000; step("R5", "R6", "R8");
    stat_wr = 1'b1; stat_wd = 8'hFF; step("R3", "R6", "R8");
    // R7 software request sets bit 2, request bit reads 0
    mask_wr = 1'b1; mask_wd = 8'hFE; step("R7", "R6", "R8");
    // R8 per-source mask blocks frame bit
    stat_wr = 1'b1; stat_wd = 8'hFF; step("R3", "R6", "R8");
    ev = 7'b0100000; mask_wr = 1'b1; mask_wd = 8'h40; step("R2", "R6", "R8");
    // R10 reserved bit ignores writes and stays 0
    stat_wr = 1'b1; stat_wd = 8'h02; mask_wr = 1'b1; mask_wd = 8'h02; step("R10", "R6", "R8");
    mask_wr = 1'b1; mask_wd = 8'h01; step("R10", "R6", "R9");

    // constrained random phase
    for (int c = 0; c < RAND_CYCLES; c++) begin
      for (int b = 0; b < 7; b++) ev[b] = (($urandom % 5) == 0);
      idle_only = (($urandom % 4) == 0);
      stat_wr   = (($urandom % 3) == 0);
      stat_wd   = 8'($urandom);
      mask_wr   = (($urandom % 6) == 0);
      mask_wd   = 8'($urandom);
      if (($urandom % 3) != 0) mask_wd[0] = 1'b0;
      step("R3", "R6", "R8");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule